// File: doc/BRIEF.md
# Host-to-DSP Shared Resource Access Arbiter

This block sits between a host processor domain and the resources inside a DSP subsystem: the DSP's internal memory and its public peripheral bus. The host issues one read or write at a time. The DSP core has its own request channel to the same two targets. A two-bit access mode picks two things: which target the host port reaches, and whether the host shares that target with the DSP or owns it outright.

In the two shared modes, the DSP and the host can both use a target. When both want the same target in the same cycle, the DSP is served and the host waits. Host transfers in these modes also pass through a fixed retiming delay before they are issued. The two host-exclusive modes may only be entered while the DSP is held in reset. In these modes the DSP is locked out of the owned target. In the exclusive memory mode, every host address is also checked. The dual-access RAM region is refused, anything past the single-access RAM window is refused, and each of the eight single-access RAM blocks must be enabled in a mask that resets to all-denied. A refused access ends at once with an error response and never reaches the target. The refusal is recorded in a sticky status flag together with the address.

Top module: `hdsp_access_arb`

## Requirements
- R1: After reset the mode is 0 (shared memory), the block-enable mask is 0, the sticky error is 0 and the host port shows no completion. Register select 0 reads the mode in bits 1:0. Select 1 reads the mask. Select 2 reads the status: error in bit 0, mode in bits 2:1, last refused address in bits 31:8.
- R2: Mode encoding: bit 1 set means host-exclusive, and bit 0 set means the peripheral bus (clear means memory). A write of a host-exclusive mode is ignored unless `dsp_in_reset` is 1. A shared mode write is always taken. While in a host-exclusive mode, a low `dsp_in_reset` reverts the mode to the shared mode for the same target on the next clock.
- R3: In a shared mode with no conflict, a host request accepted on clock edge 0 completes with `h_ready` high during cycle SYNC_LAT+2. In a host-exclusive mode it completes in cycle 2. `h_ready` is a single-cycle pulse.
- R4: In a shared mode, each cycle in which the DSP uses the host's target during the host's issue cycle gives that cycle to the DSP: the target carries the DSP address. The host completion is delayed by one cycle for each such cycle.
- R5: A DSP access to the other target proceeds in the same cycles as a host transfer. It is granted and returns that target's read data, and the host latency does not change.
- R6: In host-exclusive memory mode, host addresses below 0x010000 are refused.
- R7: In host-exclusive memory mode, host addresses at or above 0x050000 are refused.
- R8: In host-exclusive memory mode, an address A in the window is allowed only if mask bit (A-0x010000)>>15 is set. Each of the 8 blocks covers 0x8000 addresses.
- R9: A refused host access completes in cycle 1 with `h_err`=1 and `h_rdata`=0, and raises no target enable. It sets the sticky error and records the address. Writing select 2 with bit 0 set clears the error.
- R10: In a host-exclusive mode, DSP requests to the owned target get no grant and raise no target enable. DSP requests to the other target are granted.
- R11: An allowed host read returns the target's read data. An allowed host write drives the target with write enable, the host address and the host data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dsp_in_reset | input | 1 | DSP core is held in reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 mask, 2 status |
| cfg_wdata | input | NUM_BLK | Configuration write data |
| cfg_rdata | output | ADDR_W+8 | Read-back of the selected register |
| st_mode | output | 2 | Current access mode |
| st_err | output | 1 | Sticky refusal flag |
| st_err_addr | output | ADDR_W | Last refused host address |
| h_valid | input | 1 | Host request valid (sampled when idle) |
| h_write | input | 1 | Host request is a write |
| h_addr | input | ADDR_W | Host address |
| h_wdata | input | DATA_W | Host write data |
| h_ready | output | 1 | Host completion pulse |
| h_rdata | output | DATA_W | Host read data, valid with h_ready |
| h_err | output | 1 | Host refusal flag, valid with h_ready |
| d_valid | input | 1 | DSP request valid |
| d_periph | input | 1 | DSP request targets the peripheral bus |
| d_write | input | 1 | DSP request is a write |
| d_addr | input | ADDR_W | DSP address |
| d_wdata | input | DATA_W | DSP write data |
| d_grant | output | 1 | DSP request served this cycle |
| d_rdata | output | DATA_W | DSP read data |
| m_en | output | 1 | Memory target enable |
| m_we | output | 1 | Memory target write enable |
| m_addr | output | ADDR_W | Memory target address |
| m_wdata | output | DATA_W | Memory target write data |
| m_rdata | input | DATA_W | Memory target read data (same cycle) |
| p_en | output | 1 | Peripheral target enable |
| p_we | output | 1 | Peripheral target write enable |
| p_addr | output | ADDR_W | Peripheral target address |
| p_wdata | output | DATA_W | Peripheral target write data |
| p_rdata | input | DATA_W | Peripheral target read data (same cycle) |

## Verification
The hardest case to reach is a DSP conflict that lands exactly on the host's issue cycle. That cycle only comes after the retiming delay, so a DSP request raised at the wrong time never meets the host. The bench raises the DSP request on the same falling edge that presents the host request and holds it for a counted number of cycles. It checks that the memory port carries the DSP address in the stalled cycle, and that the completion moves out by exactly the overlap. The block permission logic is covered by sweeping the first and last address of every block, plus addresses on both sides of the window, under several mask patterns.

// File: rtl/hdsp_pkg.sv
// Shared constants and types of the host/DSP access arbiter.
// Assumes two targets: index 0 memory, index 1 peripheral bus.
package hdsp_pkg;
    localparam logic [1:0] MODE_SH_MEM = 2'b00;
    localparam logic [1:0] MODE_SH_PER = 2'b01;
    localparam logic [1:0] MODE_HO_MEM = 2'b10;
    localparam logic [1:0] MODE_HO_PER = 2'b11;

    localparam int NUM_TGT = 2;
    localparam int TGT_MEM = 0;
    localparam int TGT_PER = 1;

    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_SYNC  = 2'd1,
        HS_ISSUE = 2'd2,
        HS_DONE  = 2'd3
    } host_st_e;
endpackage

// File: rtl/hdsp_cfg_regs.sv
// Configuration and status registers: access mode, block-enable mask,
// sticky refusal flag and refused address. Assumes NUM_BLK >= 2 so the
// write data also carries the 2-bit mode and the clear bit.
module hdsp_cfg_regs
    import hdsp_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int NUM_BLK = 8,
    localparam int RD_W   = ADDR_W + 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dsp_in_reset,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [NUM_BLK-1:0] cfg_wdata,
    input  logic               err_set,
    input  logic [ADDR_W-1:0]  err_addr_in,
    output logic [1:0]         mode_q,
    output logic [NUM_BLK-1:0] mask_q,
    output logic               err_q,
    output logic [ADDR_W-1:0]  err_addr_q,
    output logic [RD_W-1:0]    cfg_rdata
);
    logic mode_wr, mask_wr, clr_wr;

    assign mode_wr = cfg_we && (cfg_sel == SEL_MODE);
    assign mask_wr = cfg_we && (cfg_sel == SEL_MASK);
    assign clr_wr  = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[0];

    // Mode register: exclusive modes only while the DSP is in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SH_MEM;
        end else if (mode_wr && (!cfg_wdata[1] || dsp_in_reset)) begin
            mode_q <= cfg_wdata[1:0];
        end else if (mode_q[1] && !dsp_in_reset) begin
            mode_q <= {1'b0, mode_q[0]};
        end
    end

    // Block-enable mask, all blocks denied after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= cfg_wdata;
        end
    end

    // Sticky refusal flag with its address; a new refusal beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= 1'b0;
            err_addr_q <= '0;
        end else if (err_set) begin
            err_q      <= 1'b1;
            err_addr_q <= err_addr_in;
        end else if (clr_wr) begin
            err_q      <= 1'b0;
        end
    end

    // Read-back multiplexer for the selected register.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_MODE: cfg_rdata[1:0] = mode_q;
            SEL_MASK: cfg_rdata[NUM_BLK-1:0] = mask_q;
            SEL_STAT: begin
                cfg_rdata[0]          = err_q;
                cfg_rdata[2:1]        = mode_q;
                cfg_rdata[8 +: ADDR_W] = err_addr_q;
            end
            default: cfg_rdata = '0;
        endcase
    end

    // R2: leaving DSP reset never keeps an exclusive mode.
    a_r2_exclusive_reverts: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && !dsp_in_reset) |=> !mode_q[1]);

    // R9: a refusal always leaves the sticky flag set.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> err_q);
endmodule

// File: rtl/hdsp_addr_guard.sv
// Permission check for host-exclusive memory mode. Receives only the
// block-index part of the address. Assumes RAM_BASE is block aligned.
module hdsp_addr_guard #(
    parameter int ADDR_W   = 24,
    parameter int NUM_BLK  = 8,
    parameter int BLK_BITS = 15,
    parameter int RAM_BASE = 32'h0001_0000,
    localparam int IDX_W   = ADDR_W - BLK_BITS,
    localparam int BASE_IDX = RAM_BASE >> BLK_BITS
) (
    input  logic [IDX_W-1:0]   addr_hi,
    input  logic [NUM_BLK-1:0] mask,
    output logic               permit
);
    logic [IDX_W-1:0]   rel_idx;
    logic               below;
    logic [NUM_BLK-1:0] hit;

    assign below   = addr_hi < IDX_W'(BASE_IDX);
    assign rel_idx = addr_hi - IDX_W'(BASE_IDX);

    // One comparator per enabled block; indices past the window hit nothing.
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        assign hit[b] = mask[b] && (rel_idx == IDX_W'(b));
    end

    assign permit = !below && (|hit);
endmodule

// File: rtl/hdsp_host_ctrl.sv
// Host transfer sequencer: captures a request, applies the permission
// verdict, waits out the retiming delay in shared modes, issues to the
// target (yielding to the DSP) and returns one completion pulse.
// Assumes SYNC_LAT >= 1 and a target that answers in the issue cycle.
module hdsp_host_ctrl
    import hdsp_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int SYNC_LAT = 2,
    localparam int CNT_W   = (SYNC_LAT > 1) ? $clog2(SYNC_LAT) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     mode,
    input  logic                           permit,
    input  logic                           h_valid,
    input  logic                           h_write,
    input  logic [ADDR_W-1:0]              h_addr,
    input  logic [DATA_W-1:0]              h_wdata,
    input  logic [NUM_TGT-1:0]             dsp_use,
    input  logic [NUM_TGT-1:0][DATA_W-1:0] tgt_rdata,
    output logic                           h_ready,
    output logic [DATA_W-1:0]              h_rdata,
    output logic                           h_err,
    output logic                           iss_valid,
    output logic                           iss_tgt,
    output logic                           iss_we,
    output logic [ADDR_W-1:0]              iss_addr,
    output logic [DATA_W-1:0]              iss_wdata,
    output logic                           err_set
);
    host_st_e          st_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              lat_shared;
    logic              deny;
    logic              stall;
    logic              accept;

    assign accept  = (st_q == HS_IDLE) && h_valid;
    assign deny    = (mode == MODE_HO_MEM) && !permit;
    assign err_set = accept && deny;
    assign stall   = lat_shared && dsp_use[iss_tgt];

    // Sequencer state and retiming counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= HS_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                HS_IDLE: begin
                    if (accept) begin
                        if (deny) begin
                            st_q <= HS_DONE;
                        end else if (!mode[1]) begin
                            st_q  <= HS_SYNC;
                            cnt_q <= CNT_W'(SYNC_LAT - 1);
                        end else begin
                            st_q <= HS_ISSUE;
                        end
                    end
                end
                HS_SYNC: begin
                    if (cnt_q == '0) st_q <= HS_ISSUE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                HS_ISSUE: if (!stall) st_q <= HS_DONE;
                HS_DONE:  st_q <= HS_IDLE;
                default:  st_q <= HS_IDLE;
            endcase
        end
    end

    // Request capture at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_addr   <= '0;
            iss_wdata  <= '0;
            iss_we     <= 1'b0;
            iss_tgt    <= 1'b0;
            lat_shared <= 1'b0;
        end else if (accept) begin
            iss_addr   <= h_addr;
            iss_wdata  <= h_wdata;
            iss_we     <= h_write;
            iss_tgt    <= mode[0];
            lat_shared <= !mode[1];
        end
    end

    // Response capture: zero data with error on refusal, target data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rdata <= '0;
            h_err   <= 1'b0;
        end else if (accept && deny) begin
            h_rdata <= '0;
            h_err   <= 1'b1;
        end else if ((st_q == HS_ISSUE) && !stall) begin
            h_rdata <= tgt_rdata[iss_tgt];
            h_err   <= 1'b0;
        end
    end

    assign h_ready   = (st_q == HS_DONE);
    assign iss_valid = (st_q == HS_ISSUE) && !stall;

    // R9: a refused request completes in the very next cycle with an error.
    a_r9_refuse_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |=> (h_ready && h_err && (h_rdata == '0)));

    // R3: the completion is a single-cycle pulse.
    a_r3_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |=> !h_ready);

    // R4: a host stalled by the DSP stays in its issue cycle.
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == HS_ISSUE) && stall) |=> ((st_q == HS_ISSUE) && !h_ready));
endmodule

// File: rtl/hdsp_tgt_mux.sv
// Target port steering: grants the DSP unless the host owns the target,
// gives the DSP priority on each target, and returns DSP read data.
// Assumes the host sequencer already yields when the DSP uses its target.
module hdsp_tgt_mux
    import hdsp_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     mode,
    input  logic                           d_valid,
    input  logic                           d_periph,
    input  logic                           d_write,
    input  logic [ADDR_W-1:0]              d_addr,
    input  logic [DATA_W-1:0]              d_wdata,
    input  logic                           iss_valid,
    input  logic                           iss_tgt,
    input  logic                           iss_we,
    input  logic [ADDR_W-1:0]              iss_addr,
    input  logic [DATA_W-1:0]              iss_wdata,
    input  logic [NUM_TGT-1:0][DATA_W-1:0] tgt_rdata,
    output logic                           d_grant,
    output logic [DATA_W-1:0]              d_rdata,
    output logic [NUM_TGT-1:0]             dsp_use,
    output logic [NUM_TGT-1:0]             tgt_en,
    output logic [NUM_TGT-1:0]             tgt_we,
    output logic [NUM_TGT-1:0][ADDR_W-1:0] tgt_addr,
    output logic [NUM_TGT-1:0][DATA_W-1:0] tgt_wdata
);
    logic [NUM_TGT-1:0] host_use;

    assign d_grant = d_valid && !(mode[1] && (d_periph == mode[0]));
    assign d_rdata = tgt_rdata[d_periph];

    // One steering slice per target, DSP first.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        assign dsp_use[t]   = d_grant && (d_periph == 1'(t));
        assign host_use[t]  = iss_valid && (iss_tgt == 1'(t));
        assign tgt_en[t]    = dsp_use[t] | host_use[t];
        assign tgt_we[t]    = dsp_use[t] ? d_write : (host_use[t] & iss_we);
        assign tgt_addr[t]  = dsp_use[t] ? d_addr  : iss_addr;
        assign tgt_wdata[t] = dsp_use[t] ? d_wdata : iss_wdata;

        // R4: never two masters on one target in the same cycle.
        a_r4_one_master: assert property (@(posedge clk) disable iff (!rst_n)
            !(dsp_use[t] && host_use[t]));

        // R10: the DSP never reaches a target the host owns.
        a_r10_owned_locked: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[1] && (mode[0] == 1'(t))) |-> !dsp_use[t]);
    end
endmodule

// File: rtl/hdsp_access_arb.sv
// Top of the host/DSP access arbiter: configuration registers, address
// guard, host sequencer and target steering. Target 0 is memory,
// target 1 the peripheral bus; both answer reads in the enable cycle.
module hdsp_access_arb
    import hdsp_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 16,
    parameter int NUM_BLK  = 8,
    parameter int BLK_BITS = 15,
    parameter int RAM_BASE = 32'h0001_0000,
    parameter int SYNC_LAT = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dsp_in_reset,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [NUM_BLK-1:0] cfg_wdata,
    output logic [ADDR_W+7:0]  cfg_rdata,
    output logic [1:0]         st_mode,
    output logic               st_err,
    output logic [ADDR_W-1:0]  st_err_addr,
    input  logic               h_valid,
    input  logic               h_write,
    input  logic [ADDR_W-1:0]  h_addr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic               h_ready,
    output logic [DATA_W-1:0]  h_rdata,
    output logic               h_err,
    input  logic               d_valid,
    input  logic               d_periph,
    input  logic               d_write,
    input  logic [ADDR_W-1:0]  d_addr,
    input  logic [DATA_W-1:0]  d_wdata,
    output logic               d_grant,
    output logic [DATA_W-1:0]  d_rdata,
    output logic               m_en,
    output logic               m_we,
    output logic [ADDR_W-1:0]  m_addr,
    output logic [DATA_W-1:0]  m_wdata,
    input  logic [DATA_W-1:0]  m_rdata,
    output logic               p_en,
    output logic               p_we,
    output logic [ADDR_W-1:0]  p_addr,
    output logic [DATA_W-1:0]  p_wdata,
    input  logic [DATA_W-1:0]  p_rdata
);
    logic [1:0]                     mode;
    logic [NUM_BLK-1:0]             mask;
    logic                           permit;
    logic                           err_set;
    logic [NUM_TGT-1:0]             dsp_use;
    logic [NUM_TGT-1:0][DATA_W-1:0] tgt_rdata;
    logic [NUM_TGT-1:0]             tgt_en, tgt_we;
    logic [NUM_TGT-1:0][ADDR_W-1:0] tgt_addr;
    logic [NUM_TGT-1:0][DATA_W-1:0] tgt_wdata;
    logic                           iss_valid, iss_tgt, iss_we;
    logic [ADDR_W-1:0]              iss_addr;
    logic [DATA_W-1:0]              iss_wdata;

    assign tgt_rdata[TGT_MEM] = m_rdata;
    assign tgt_rdata[TGT_PER] = p_rdata;
    assign m_en    = tgt_en[TGT_MEM];
    assign m_we    = tgt_we[TGT_MEM];
    assign m_addr  = tgt_addr[TGT_MEM];
    assign m_wdata = tgt_wdata[TGT_MEM];
    assign p_en    = tgt_en[TGT_PER];
    assign p_we    = tgt_we[TGT_PER];
    assign p_addr  = tgt_addr[TGT_PER];
    assign p_wdata = tgt_wdata[TGT_PER];
    assign st_mode = mode;

    hdsp_cfg_regs #(.ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK)) i_cfg (
        .clk(clk), .rst_n(rst_n), .dsp_in_reset(dsp_in_reset),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .err_set(err_set), .err_addr_in(h_addr),
        .mode_q(mode), .mask_q(mask), .err_q(st_err),
        .err_addr_q(st_err_addr), .cfg_rdata(cfg_rdata)
    );

    hdsp_addr_guard #(.ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK),
                      .BLK_BITS(BLK_BITS), .RAM_BASE(RAM_BASE)) i_guard (
        .addr_hi(h_addr[ADDR_W-1:BLK_BITS]), .mask(mask), .permit(permit)
    );

    hdsp_host_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_LAT(SYNC_LAT)) i_host (
        .clk(clk), .rst_n(rst_n), .mode(mode), .permit(permit),
        .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
        .dsp_use(dsp_use), .tgt_rdata(tgt_rdata),
        .h_ready(h_ready), .h_rdata(h_rdata), .h_err(h_err),
        .iss_valid(iss_valid), .iss_tgt(iss_tgt), .iss_we(iss_we),
        .iss_addr(iss_addr), .iss_wdata(iss_wdata), .err_set(err_set)
    );

    hdsp_tgt_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mux (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .d_valid(d_valid), .d_periph(d_periph), .d_write(d_write),
        .d_addr(d_addr), .d_wdata(d_wdata),
        .iss_valid(iss_valid), .iss_tgt(iss_tgt), .iss_we(iss_we),
        .iss_addr(iss_addr), .iss_wdata(iss_wdata), .tgt_rdata(tgt_rdata),
        .d_grant(d_grant), .d_rdata(d_rdata), .dsp_use(dsp_use),
        .tgt_en(tgt_en), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata)
    );

    // R6: an exclusive-memory host request into dual-access RAM is refused.
    a_r6_dual_ram_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (h_valid && !h_ready && (mode == MODE_HO_MEM) && (h_addr < ADDR_W'(RAM_BASE))) |-> !permit);
endmodule

// File: tb/test_hdsp_access_arb.sv
module test_hdsp_access_arb;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int NB = 8;
    localparam int SL = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, dsp_in_reset, cfg_we;
    logic [1:0] cfg_sel;
    logic [NB-1:0] cfg_wdata;
    logic [AW+7:0] cfg_rdata;
    logic [1:0] st_mode;
    logic st_err;
    logic [AW-1:0] st_err_addr;
    logic h_valid, h_write, h_ready, h_err;
    logic [AW-1:0] h_addr;
    logic [DW-1:0] h_wdata, h_rdata;
    logic d_valid, d_periph, d_write, d_grant;
    logic [AW-1:0] d_addr;
    logic [DW-1:0] d_wdata, d_rdata;
    logic m_en, m_we, p_en, p_we;
    logic [AW-1:0] m_addr, p_addr;
    logic [DW-1:0] m_wdata, m_rdata, p_wdata, p_rdata;

    int n_checks = 0;
    int n_fail = 0;
    int m_cnt = 0;
    int p_cnt = 0;
    logic last_m_we;
    logic [AW-1:0] last_m_addr;
    logic [DW-1:0] last_m_wdata;

    function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
        return a[15:0] ^ {8'h00, a[23:16]} ^ 16'hC3C3;
    endfunction
    function automatic logic [DW-1:0] per_f(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A5A;
    endfunction

    assign m_rdata = mem_f(m_addr);
    assign p_rdata = per_f(p_addr);

    hdsp_access_arb i_hdsp_access_arb (
        .clk(clk), .rst_n(rst_n), .dsp_in_reset(dsp_in_reset),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .st_mode(st_mode), .st_err(st_err), .st_err_addr(st_err_addr),
        .h_valid(h_valid), .h_write(h_write), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_ready(h_ready), .h_rdata(h_rdata), .h_err(h_err),
        .d_valid(d_valid), .d_periph(d_periph), .d_write(d_write), .d_addr(d_addr),
        .d_wdata(d_wdata), .d_grant(d_grant), .d_rdata(d_rdata),
        .m_en(m_en), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .p_en(p_en), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata)
    );

    // Target activity monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (m_en) begin
            m_cnt = m_cnt + 1;
            last_m_we = m_we;
            last_m_addr = m_addr;
            last_m_wdata = m_wdata;
        end
        if (p_en) p_cnt = p_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [NB-1:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [31:0] data);
        cfg_sel = sel;
        #1 data = cfg_rdata;
        @(negedge clk);
    endtask

    // Called at a falling edge; returns at a falling edge one idle cycle after completion.
    task automatic host_xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                             output logic [DW-1:0] rd, output logic er, output int lat);
        h_valid = 1'b1; h_write = wr; h_addr = a; h_wdata = wd;
        lat = 0;
        @(negedge clk);
        lat = 1;
        h_valid = 1'b0;
        while (!h_ready && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        rd = h_rdata;
        er = h_err;
        @(negedge clk);
    endtask

    function automatic logic [NB-1:0] mask_of(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'hA5;
            3: return 8'h3C;
            default: return 8'h81;
        endcase
    endfunction

    function automatic logic [AW-1:0] addr_of(input int k);
        if (k < 16) return AW'(32'h10000 + (k / 2) * 32'h8000 + ((k % 2) != 0 ? 32'h7FFF : 32'h0));
        case (k)
            16: return 24'h000000;
            17: return 24'h00FFFF;
            18: return 24'h050000;
            default: return 24'h0FFFFF;
        endcase
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        logic [DW-1:0] rd;
        logic er;
        int lat;
        int m0;
        rst_n = 0; dsp_in_reset = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        h_valid = 0; h_write = 0; h_addr = 0; h_wdata = 0;
        d_valid = 0; d_periph = 0; d_write = 0; d_addr = 0; d_wdata = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(st_mode == 2'b00, "R1 mode after reset", 32'(st_mode), 0);
        chk(st_err == 1'b0, "R1 error after reset", 32'(st_err), 0);
        chk(h_ready == 1'b0, "R1 no completion after reset", 32'(h_ready), 0);
        cfg_read(2'd1, rv);
        chk(rv == 0, "R1 mask readback after reset", rv, 0);
        cfg_read(2'd2, rv);
        chk(rv == 0, "R1 status readback after reset", rv, 0);

        // R2 mode write rules
        cfg_write(2'd0, 8'd2);
        cfg_read(2'd0, rv);
        chk(rv == 0, "R2 exclusive mode refused outside DSP reset", rv, 0);
        cfg_write(2'd0, 8'd1);
        cfg_read(2'd0, rv);
        chk(rv == 1, "R2 shared mode accepted", rv, 1);
        dsp_in_reset = 1;
        cfg_write(2'd0, 8'd3);
        chk(st_mode == 2'd3, "R2 exclusive mode accepted in DSP reset", 32'(st_mode), 3);
        dsp_in_reset = 0;
        @(negedge clk);
        chk(st_mode == 2'd1, "R2 revert on leaving DSP reset", 32'(st_mode), 1);

        // R3 shared latency, memory and peripheral
        cfg_write(2'd0, 8'd0);
        m0 = m_cnt;
        host_xfer(1'b0, 24'h012345, '0, rd, er, lat);
        chk(lat == SL + 2, "R3 shared memory latency", 32'(lat), 32'(SL + 2));
        chk(rd == mem_f(24'h012345) && !er, "R11 shared memory read data", 32'(rd), 32'(mem_f(24'h012345)));
        chk(m_cnt == m0 + 1, "R11 one memory access", 32'(m_cnt - m0), 1);
        host_xfer(1'b0, 24'h000010, '0, rd, er, lat);
        chk(!er && rd == mem_f(24'h000010), "R6 dual RAM open in shared mode", 32'(rd), 32'(mem_f(24'h000010)));
        cfg_write(2'd0, 8'd1);
        host_xfer(1'b0, 24'h000040, '0, rd, er, lat);
        chk(lat == SL + 2 && rd == per_f(24'h000040), "R3 shared peripheral read", 32'(rd), 32'(per_f(24'h000040)));

        // R4 DSP wins a same-target conflict for two cycles
        cfg_write(2'd0, 8'd0);
        d_periph = 0; d_write = 0; d_addr = 24'h000123;
        fork
            host_xfer(1'b0, 24'h020202, '0, rd, er, lat);
            begin
                d_valid = 1;
                repeat (3) @(negedge clk);
                chk(m_addr == 24'h000123 && d_grant, "R4 DSP owns memory in conflict", 32'(m_addr), 32'h123);
                repeat (2) @(negedge clk);
                d_valid = 0;
            end
        join
        chk(lat == SL + 4, "R4 host delayed by conflict", 32'(lat), 32'(SL + 4));
        chk(rd == mem_f(24'h020202), "R4 host data after conflict", 32'(rd), 32'(mem_f(24'h020202)));

        // R5 DSP on the other target runs in parallel
        d_valid = 1; d_periph = 1; d_addr = 24'h000777;
        host_xfer(1'b0, 24'h030303, '0, rd, er, lat);
        chk(lat == SL + 2, "R5 host latency unchanged", 32'(lat), 32'(SL + 2));
        chk(d_grant && d_rdata == per_f(24'h000777), "R5 DSP peripheral served", 32'(d_rdata), 32'(per_f(24'h000777)));
        d_valid = 0;

        // R6 R7 R8 R9 permission sweep in exclusive memory mode
        dsp_in_reset = 1;
        cfg_write(2'd0, 8'd2);
        for (int mi = 0; mi < 5; mi++) begin
            logic [NB-1:0] msk;
            msk = mask_of(mi);
            cfg_write(2'd1, msk);
            for (int k = 0; k < 20; k++) begin
                logic [AW-1:0] a;
                logic allow;
                a = addr_of(k);
                allow = (a >= 24'h010000) && (a < 24'h050000) && msk[(32'(a) - 32'h10000) >> 15];
                m0 = m_cnt;
                host_xfer(1'b0, a, '0, rd, er, lat);
                if (allow) begin
                    chk(!er && rd == mem_f(a) && lat == 2, "R8 allowed block read", 32'(rd), 32'(mem_f(a)));
                    chk(m_cnt == m0 + 1, "R8 allowed block reaches memory", 32'(m_cnt - m0), 1);
                end else begin
                    if (a < 24'h010000) chk(er, "R6 dual RAM refused", 32'(er), 1);
                    else if (a >= 24'h050000) chk(er, "R7 above window refused", 32'(er), 1);
                    else chk(er, "R8 disabled block refused", 32'(er), 1);
                    chk(rd == 0 && lat == 1, "R9 refusal data and latency", {16'(lat), rd}, 32'h0001_0000);
                    chk(m_cnt == m0, "R9 refusal raises no enable", 32'(m_cnt - m0), 0);
                    chk(st_err && st_err_addr == a, "R9 sticky error and address", 32'(st_err_addr), 32'(a));
                    cfg_write(2'd2, 8'd1);
                    chk(!st_err, "R9 error cleared", 32'(st_err), 0);
                end
            end
        end

        // R11 allowed write, R9 refused write
        cfg_write(2'd1, 8'hFF);
        host_xfer(1'b1, 24'h018000, 16'hBEEF, rd, er, lat);
        chk(!er && last_m_we && last_m_addr == 24'h018000 && last_m_wdata == 16'hBEEF,
            "R11 write forwarded", {last_m_addr, 8'h00} | 32'(last_m_wdata), 32'h0180_BEEF);
        m0 = m_cnt;
        host_xfer(1'b1, 24'h000100, 16'h1111, rd, er, lat);
        chk(er && m_cnt == m0, "R9 refused write not forwarded", 32'(m_cnt - m0), 0);
        cfg_write(2'd2, 8'd1);

        // R10 DSP lock-out in exclusive modes
        cfg_write(2'd0, 8'd3);
        d_valid = 1; d_periph = 1; d_addr = 24'h000050;
        #1;
        chk(!d_grant && !p_en, "R10 DSP peripheral blocked", {31'd0, d_grant}, 0);
        @(negedge clk);
        d_periph = 0;
        #1;
        chk(d_grant && m_en, "R10 DSP memory granted in peripheral exclusive", {31'd0, d_grant}, 1);
        @(negedge clk);
        d_valid = 0;
        host_xfer(1'b0, 24'h000060, '0, rd, er, lat);
        chk(lat == 2 && !er && rd == per_f(24'h000060), "R3 exclusive peripheral latency", 32'(lat), 2);
        cfg_write(2'd0, 8'd2);
        d_valid = 1; d_periph = 0;
        #1;
        chk(!d_grant && !m_en, "R10 DSP memory blocked", {31'd0, d_grant}, 0);
        @(negedge clk);
        d_valid = 0;
        @(negedge clk);

        finish_run();
    end
endmodule